// File: doc/BRIEF.md
# Packed Palette Loader

This block holds a 256-entry color lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the table through two bus registers. It first writes a starting entry number to an index register. It then streams 32-bit words to a color data port. Each word is split into four bytes, most significant byte first. The bytes fill components in red, green, blue order and move on to the next entry after every blue byte. Three words therefore fill four entries exactly. An entry may be split across two words, because a byte cursor carries the component phase from one word to the next.

The display side reads the table with an 8-bit pixel value. The 24-bit color appears one clock later. The same index register also selects one of a small bank of control bytes. A separate control port loads the selected byte. Several of these bytes hold fixed power-on values.

Top module: `clut_packed_loader`

## Requirements
- R1: After reset every table entry reads as 0x000000. Control bytes 4, 5, 6 and 7 hold 0xFF, 0x00, 0x70 and 0x00, and all other control bytes hold 0x00. The control bank output packs byte n at bits [8n+7:8n].
- R2: A bus write with select 0 (the index register) loads the entry pointer from data bits [7:0] and sets the component phase to red. This applies even part-way through an entry.
- R3: A bus write with select 1 (color data) unpacks the word in the order bits [31:24], [23:16], [15:8], [7:0]. The bytes land in red, green, blue order on consecutive entries, starting at the pointer. Three words written after an index write fill exactly four entries.
- R4: A word that ends inside an entry writes only the components it covers. The next color word continues at the following component of that same entry.
- R5: The entry pointer wraps from 255 to 0 inside a word.
- R6: The display read returns the color stored at the pixel index on the clock edge after that index is presented, with one cycle of latency.
- R7: When a color write and a display read hit the same entry in the same cycle, the read returns the value from before the write.
- R8: A bus write with select 2 (control data) loads data bits [7:0] into the control byte numbered by the index register.
- R9: A control write whose index register value is 8 or more changes no control byte. A bus write with select 3 changes neither the table nor the byte cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Bus write strobe, one word per cycle |
| bus_sel_i | input | 2 | Register select: 0 index, 1 color data, 2 control data, 3 none |
| bus_wdata_i | input | 32 | Bus write data |
| pix_idx_i | input | 8 | Pixel value used as the display read index |
| pix_rgb_o | output | 24 | Color of the indexed entry, red in [23:16], blue in [7:0] |
| ctl_regs_o | output | 64 | Control bytes, byte n at bits [8n+7:8n] |

## Verification
The hardest case to reach is a byte cursor that sits inside an entry at a word boundary. The same holds when that boundary lines up with the wrap from entry 255 to 0, and when the index register is rewritten while an entry is half filled. The stimulus gets there with single color words rather than whole groups of three. It starts at index 255 so that one word wraps. It rewrites the index between two words and reads back the entry that was half filled, so each component can be seen on its own. A separate directed step presents a display read and a color write to the same entry in one cycle. It checks the old value first and the new value one cycle later.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_COLOR = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } bus_sel_e;

  localparam int COMP_PER_ENTRY = 3;

  function automatic logic [7:0] ctrl_reset_value(input int unsigned n);
    case (n)
      4:       ctrl_reset_value = 8'hFF;
      6:       ctrl_reset_value = 8'h70;
      default: ctrl_reset_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pal_byte_steer.sv
`timescale 1ns/1ps
module pal_byte_steer #(
  parameter int ENT_W = 8,
  parameter int LANES = 4
) (
  input  logic [ENT_W-1:0]             ptr_i,
  input  logic [1:0]                   phase_i,
  output logic [LANES-1:0][ENT_W-1:0]  lane_ent_o,
  output logic [LANES-1:0][1:0]        lane_comp_o,
  output logic [ENT_W-1:0]             ptr_next_o,
  output logic [1:0]                   phase_next_o
);
  import pal_pkg::*;

  localparam int POS_W = $clog2(LANES + COMP_PER_ENTRY) + 1;
  localparam logic [POS_W-1:0] NCOMP = POS_W'(COMP_PER_ENTRY);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [POS_W-1:0] pos;
    assign pos             = POS_W'(phase_i) + POS_W'(k);
    assign lane_comp_o[k]  = 2'(pos % NCOMP);
    assign lane_ent_o[k]   = ptr_i + ENT_W'(pos / NCOMP);
  end

  logic [POS_W-1:0] pos_end;
  assign pos_end      = POS_W'(phase_i) + POS_W'(LANES);
  assign phase_next_o = 2'(pos_end % NCOMP);
  assign ptr_next_o   = ptr_i + ENT_W'(pos_end / NCOMP);

endmodule

// File: rtl/pal_clut_store.sv
`timescale 1ns/1ps
module pal_clut_store #(
  parameter int ENT_W = 8,
  parameter int LANES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             lane_we_i,
  input  logic [LANES-1:0][ENT_W-1:0]  lane_ent_i,
  input  logic [LANES-1:0][1:0]        lane_comp_i,
  input  logic [LANES-1:0][7:0]        lane_byte_i,
  input  logic [ENT_W-1:0]             rd_idx_i,
  output logic [23:0]                  rd_rgb_o
);

  localparam int DEPTH = 1 << ENT_W;

  logic [23:0] ent_flat [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [7:0] red_q, grn_q, blu_q;
    logic [7:0] red_d, grn_d, blu_d;
    logic       ent_en;

    always_comb begin
      red_d  = red_q;
      grn_d  = grn_q;
      blu_d  = blu_q;
      ent_en = 1'b0;
      for (int k = 0; k < LANES; k++) begin
        if (lane_we_i[k] && (lane_ent_i[k] == ENT_W'(e))) begin
          ent_en = 1'b1;
          case (lane_comp_i[k])
            2'd0:    red_d = lane_byte_i[k];
            2'd1:    grn_d = lane_byte_i[k];
            default: blu_d = lane_byte_i[k];
          endcase
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        red_q <= '0;
        grn_q <= '0;
        blu_q <= '0;
      end else if (ent_en) begin
        red_q <= red_d;
        grn_q <= grn_d;
        blu_q <= blu_d;
      end
    end

    assign ent_flat[e] = {red_q, grn_q, blu_q};
  end

  logic [23:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= ent_flat[rd_idx_i];
  end

  assign rd_rgb_o = rd_q;

  // Guard for R6: an unchanged index with no write in between keeps the output steady.
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r6_read_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $stable(rd_idx_i) && !$past(|lane_we_i)) |=> $stable(rd_rgb_o));

endmodule

// File: rtl/pal_ctrl_bank.sv
`timescale 1ns/1ps
module pal_ctrl_bank #(
  parameter int N_SUB  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      sub_i,
  input  logic [7:0]             byte_i,
  output logic [N_SUB-1:0][7:0]  regs_o
);
  import pal_pkg::*;

  logic in_range;
  assign in_range = (32'(sub_i) < N_SUB);

  for (genvar n = 0; n < N_SUB; n++) begin : g_sub
    logic [7:0] sub_q;
    logic       sub_en;
    assign sub_en = we_i && in_range && (32'(sub_i) == n);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sub_q <= ctrl_reset_value(n);
      else if (sub_en) sub_q <= byte_i;
    end

    assign regs_o[n] = sub_q;
  end

  a_r9_ctrl_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_range) |=> $stable(regs_o));

  a_r8_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_range) |=> (regs_o[$past(sub_i[$clog2(N_SUB)-1:0])] == $past(byte_i)));

endmodule

// File: rtl/clut_packed_loader.sv
`timescale 1ns/1ps
module clut_packed_loader #(
  parameter int ENT_W  = 8,
  parameter int DATA_W = 32,
  parameter int N_SUB  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic [1:0]          bus_sel_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  logic [ENT_W-1:0]    pix_idx_i,
  output logic [23:0]         pix_rgb_o,
  output logic [N_SUB*8-1:0]  ctl_regs_o
);
  import pal_pkg::*;

  localparam int LANES = DATA_W / 8;

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic idx_we, color_we, ctrl_we;
  assign idx_we   = bus_wr_i && (bus_sel_i == SEL_INDEX);
  assign color_we = bus_wr_i && (bus_sel_i == SEL_COLOR);
  assign ctrl_we  = bus_wr_i && (bus_sel_i == SEL_CTRL);

  logic [ENT_W-1:0] ptr_q, ptr_d, ptr_adv;
  logic [1:0]       phase_q, phase_d, phase_adv;
  logic [ENT_W-1:0] index_q, index_d;
  logic             cursor_en;

  logic [LANES-1:0][ENT_W-1:0] lane_ent;
  logic [LANES-1:0][1:0]       lane_comp;
  logic [LANES-1:0][7:0]       lane_byte;
  logic [LANES-1:0]            lane_we;

  pal_byte_steer #(.ENT_W(ENT_W), .LANES(LANES)) i_steer (
    .ptr_i        (ptr_q),
    .phase_i      (phase_q),
    .lane_ent_o   (lane_ent),
    .lane_comp_o  (lane_comp),
    .ptr_next_o   (ptr_adv),
    .phase_next_o (phase_adv)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bytes
    assign lane_byte[k] = bus_wdata_i[DATA_W-1-8*k -: 8];
    assign lane_we[k]   = color_we;
  end

  always_comb begin
    ptr_d     = ptr_q;
    phase_d   = phase_q;
    index_d   = index_q;
    cursor_en = 1'b0;
    if (idx_we) begin
      ptr_d     = bus_wdata_i[ENT_W-1:0];
      phase_d   = 2'd0;
      index_d   = bus_wdata_i[ENT_W-1:0];
      cursor_en = 1'b1;
    end else if (color_we) begin
      ptr_d     = ptr_adv;
      phase_d   = phase_adv;
      cursor_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      phase_q <= '0;
      index_q <= '0;
    end else if (cursor_en) begin
      ptr_q   <= ptr_d;
      phase_q <= phase_d;
      index_q <= index_d;
    end
  end

  pal_clut_store #(.ENT_W(ENT_W), .LANES(LANES)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .lane_we_i   (lane_we),
    .lane_ent_i  (lane_ent),
    .lane_comp_i (lane_comp),
    .lane_byte_i (lane_byte),
    .rd_idx_i    (pix_idx_i),
    .rd_rgb_o    (pix_rgb_o)
  );

  logic [N_SUB-1:0][7:0] ctl_regs;

  pal_ctrl_bank #(.N_SUB(N_SUB), .ADDR_W(ENT_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (ctrl_we),
    .sub_i  (index_q),
    .byte_i (bus_wdata_i[7:0]),
    .regs_o (ctl_regs)
  );

  assign ctl_regs_o = ctl_regs;

  a_r2_index_load: assert property (@(posedge clk_i) disable iff (!rst_n)
    idx_we |=> (phase_q == 2'd0) && (ptr_q == $past(bus_wdata_i[ENT_W-1:0])));

  a_r3_phase_legal: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase_q != 2'd3);

  a_r9_cursor_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!idx_we && !color_we) |=> ($stable(ptr_q) && $stable(phase_q)));

endmodule

// File: tb/test_clut_packed_loader.sv
`timescale 1ns/1ps
module test_clut_packed_loader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_sel;
  logic [31:0] bus_wdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;
  logic [63:0] ctl_regs;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clut_packed_loader i_clut_packed_loader (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_sel_i   (bus_sel),
    .bus_wdata_i (bus_wdata),
    .pix_idx_i   (pix_idx),
    .pix_rgb_o   (pix_rgb),
    .ctl_regs_o  (ctl_regs)
  );

  // {start index, three words, four expected entries}
  localparam logic [199:0] VECS [4] = '{
    {8'h00, 96'h11223344_55667788_99AABBCC, 96'h112233_445566_778899_AABBCC},
    {8'h08, 96'hFF000000_00FF0000_0000FF00, 96'hFF0000_0000FF_000000_00FF00},
    {8'h40, 96'h01020304_05060708_090A0B0C, 96'h010203_040506_070809_0A0B0C},
    {8'hFC, 96'hDEADBEEF_CAFEF00D_12345678, 96'hDEADBE_EFCAFE_F00D12_345678}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_sel   = sel;
    bus_wdata = data;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [23:0] val);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    val = pix_rgb;
  endtask

  task automatic expect_entry(input string req, input logic [7:0] idx, input logic [23:0] exp);
    logic [23:0] v;
    rd(idx, v);
    check(req, 64'(v), 64'(exp));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 2'd3; bus_wdata = '0; pix_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_entry("R1 entry 0", 8'h00, 24'h000000);
    expect_entry("R1 entry 255", 8'hFF, 24'h000000);
    check("R1 ctrl bank", ctl_regs, 64'h0070_00FF_0000_0000);

    // R3 table walk: three words fill four entries; R6 latency used by reads
    for (int i = 0; i < 4; i++) begin
      bw(2'd0, {24'h0, VECS[i][199:192]});
      for (int w = 0; w < 3; w++) bw(2'd1, VECS[i][191-32*w -: 32]);
      for (int e = 0; e < 4; e++)
        expect_entry("R3 packed fill", VECS[i][199:192] + 8'(e), VECS[i][95-24*e -: 24]);
    end

    // R4 word ending mid-entry, then continued by the next word
    bw(2'd0, 32'h20);
    bw(2'd1, 32'hA1B2C3D4);
    expect_entry("R4 full entry", 8'h20, 24'hA1B2C3);
    expect_entry("R4 red only", 8'h21, 24'hD40000);
    bw(2'd1, 32'hE5F60718);
    expect_entry("R4 continued entry", 8'h21, 24'hD4E5F6);
    expect_entry("R4 partial next", 8'h22, 24'h071800);

    // R5 wrap from 255 to 0 inside one word
    bw(2'd0, 32'hFF);
    bw(2'd1, 32'h10203040);
    expect_entry("R5 entry 255", 8'hFF, 24'h102030);
    expect_entry("R5 wrapped red", 8'h00, 24'h402233);

    // R2 index rewrite mid-entry resets phase to red
    bw(2'd0, 32'h30);
    bw(2'd1, 32'hAABBCCDD);
    bw(2'd0, 32'h31);
    bw(2'd1, 32'h01020304);
    expect_entry("R2 restart at red", 8'h31, 24'h010203);
    expect_entry("R2 following red", 8'h32, 24'h040000);

    // R6 / R7 same-cycle write and read of one entry
    bw(2'd0, 32'h50);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 32'h77889900; pix_idx = 8'h50;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 old value on collision", 64'(pix_rgb), 64'h000000);
    @(negedge clk);
    check("R6 new value one cycle later", 64'(pix_rgb), 64'h778899);

    // R8 control path through the index register
    bw(2'd0, 32'h05);
    bw(2'd2, 32'h123456AB);
    check("R8 ctrl byte 5", ctl_regs, 64'h0070_ABFF_0000_0000);
    bw(2'd0, 32'h00);
    bw(2'd2, 32'h0000003C);
    check("R8 ctrl byte 0", ctl_regs, 64'h0070_ABFF_0000_003C);

    // R9 out-of-range control index and the unused select
    bw(2'd0, 32'h09);
    bw(2'd2, 32'h00000055);
    check("R9 ctrl unchanged", ctl_regs, 64'h0070_ABFF_0000_003C);
    bw(2'd0, 32'h60);
    bw(2'd3, 32'hFFFFFFFF);
    expect_entry("R9 select 3 no write", 8'h60, 24'h000000);
    bw(2'd1, 32'h01020304);
    expect_entry("R9 cursor not moved", 8'h60, 24'h010203);

    rd(8'h00, v);
    check("R5 wrapped entry kept", 64'(v), 64'h402233);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule